// File: doc/BRIEF.md
# Adaptive Clock Period Selector

This block chooses, every cycle, the shortest clock period that a group of functional units can tolerate under their present operating conditions. Each unit has quantized sensor readings for process spread, device aging, temperature and supply voltage. Each unit also owns a programmable table that maps those readings, together with a target timing-error-rate class, to a minimum period code. The selected code is registered and sent to an external clock generator. Code n stands for n × 0.2 ns, so the legal codes 1 to 24 span 0.2 ns to 4.8 ns. Code 24 is the safe worst case.

The block has two modes. In per-instruction mode, only the units that the current instruction uses are consulted, each with its own sensor readings. The largest of their codes is applied. In kernel mode, a single representative sensor set for the whole execute stage is looked up in every unit's table, and the largest result is applied. A simple write port fills the tables. It is expected to be loaded from an offline characterization step before adaptive operation starts.

Top module: `adaptive_period_sel`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `period_code` is 24, and every table entry holds 24.
- R2: A table entry is addressed by unit, class, process, aging, temperature and voltage. When a write with a legal address and a code between 1 and 24 is followed by a per-instruction lookup of that unit at the same address, the written code appears on `period_code` one cycle after the lookup inputs are presented.
- R3: In per-instruction mode with `instr_valid` high, the output is the largest looked-up code among the units whose bit is set in `unit_use`.
- R4: In per-instruction mode, a unit whose `unit_use` bit is clear has no effect on the result, whatever its table holds.
- R5: When `coarse_mode` is 1, the representative readings are looked up in every unit's table and the largest result is applied. This happens every cycle, regardless of `instr_valid` and `unit_use`.
- R6: In per-instruction mode, when `instr_valid` is low, `period_code` keeps its previous value.
- R7: In per-instruction mode, when `instr_valid` is high and `unit_use` is all zero, `period_code` keeps its previous value.
- R8: The class field (0 is error-free, 1 is low, 2 is medium, 3 is high error rate) selects a separate section of each table. `target_cls` picks the section that is read.
- R9: Out-of-range read codes fall back to the most pessimistic entry. An aging code above 4 reads as 4. A temperature code above 3 reads as 3 (the hottest). A voltage code above 3 reads as 0 (the lowest). Process codes 0 to 3 are all legal.
- R10: A write whose code is 0 or greater than 24 stores 24.
- R11: A write whose unit index is at or above the unit count, or whose aging code is above 4, or whose temperature or voltage code is above 3, changes no entry.
- R12: After reset, `period_code` is always between 1 and 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Table write strobe |
| wr_unit | input | UW | Unit index of the write |
| wr_cls | input | 2 | Error-rate class of the write |
| wr_proc | input | 2 | Process code of the write |
| wr_age | input | 3 | Aging code of the write |
| wr_temp | input | 3 | Temperature code of the write |
| wr_volt | input | 3 | Voltage code of the write |
| wr_code | input | 5 | Period code to store |
| target_cls | input | 2 | Target error-rate class for lookups |
| coarse_mode | input | 1 | 1 selects kernel mode with representative readings |
| instr_valid | input | 1 | Instruction present in per-instruction mode |
| unit_use | input | NUM_UNITS | One bit per unit used by the instruction |
| sens_proc | input | 2*NUM_UNITS | Per-unit process codes, unit u at bits [2u+1:2u] |
| sens_age | input | 3*NUM_UNITS | Per-unit aging codes, unit u at bits [3u+2:3u] |
| sens_temp | input | 3*NUM_UNITS | Per-unit temperature codes |
| sens_volt | input | 3*NUM_UNITS | Per-unit voltage codes |
| rep_proc | input | 2 | Representative process code |
| rep_age | input | 3 | Representative aging code |
| rep_temp | input | 3 | Representative temperature code |
| rep_volt | input | 3 | Representative voltage code |
| period_code | output | 5 | Selected period code for the clock generator |

## Verification
The lookup and maximum logic is combinational and feeds one output register. A lookup therefore appears on `period_code` at the first rising edge after its inputs are presented. A table write lands on its own edge, and a lookup of that entry takes one further edge. The bench drives inputs on the falling edge and samples the output on the next falling edge, after exactly one rising edge. Writes always finish a full cycle before any lookup that depends on them. For the hold cases, the expected value is the previous expected code, carried forward in the bench's own model.

// File: rtl/adaptive_period_sel.sv
module adaptive_period_sel #(
  parameter int NUM_UNITS = 3,
  parameter int P_LV      = 4,
  parameter int A_LV      = 5,
  parameter int T_LV      = 4,
  parameter int V_LV      = 4,
  parameter int CODE_MAX  = 24,
  parameter int UW        = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [UW-1:0]          wr_unit,
  input  logic [1:0]             wr_cls,
  input  logic [1:0]             wr_proc,
  input  logic [2:0]             wr_age,
  input  logic [2:0]             wr_temp,
  input  logic [2:0]             wr_volt,
  input  logic [4:0]             wr_code,
  input  logic [1:0]             target_cls,
  input  logic                   coarse_mode,
  input  logic                   instr_valid,
  input  logic [NUM_UNITS-1:0]   unit_use,
  input  logic [2*NUM_UNITS-1:0] sens_proc,
  input  logic [3*NUM_UNITS-1:0] sens_age,
  input  logic [3*NUM_UNITS-1:0] sens_temp,
  input  logic [3*NUM_UNITS-1:0] sens_volt,
  input  logic [1:0]             rep_proc,
  input  logic [2:0]             rep_age,
  input  logic [2:0]             rep_temp,
  input  logic [2:0]             rep_volt,
  output logic [4:0]             period_code
);

  localparam int DEPTH = 4 * P_LV * A_LV * T_LV * V_LV;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [4:0] SAFE = 5'(CODE_MAX);

  function automatic logic [AW-1:0] lin(input logic [1:0] c, input int p, input int a,
                                        input int t, input int v);
    int r;
    r = (((int'(c) * P_LV + p) * A_LV + a) * T_LV + t) * V_LV + v;
    return AW'(r);
  endfunction

  function automatic logic [AW-1:0] rd_idx(input logic [1:0] c, input logic [1:0] p,
                                           input logic [2:0] a, input logic [2:0] t,
                                           input logic [2:0] v);
    int pc, ac, tc, vc;
    pc = (int'(p) >= P_LV) ? P_LV - 1 : int'(p);
    ac = (int'(a) >= A_LV) ? A_LV - 1 : int'(a);
    tc = (int'(t) >= T_LV) ? T_LV - 1 : int'(t);
    vc = (int'(v) >= V_LV) ? 0 : int'(v);
    return lin(c, pc, ac, tc, vc);
  endfunction

  logic [4:0] tab [NUM_UNITS][DEPTH];
  logic [4:0] need [NUM_UNITS];
  logic [4:0] mx;
  logic       wr_ok, upd;
  logic [4:0] wr_val;

  assign wr_ok = wr_en && (int'(wr_unit) < NUM_UNITS) && (int'(wr_proc) < P_LV) &&
                 (int'(wr_age) < A_LV) && (int'(wr_temp) < T_LV) && (int'(wr_volt) < V_LV);
  assign wr_val = (wr_code == 5'd0 || wr_code > SAFE) ? SAFE : wr_code;
  assign upd = coarse_mode || (instr_valid && |unit_use);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int u = 0; u < NUM_UNITS; u++)
        for (int i = 0; i < DEPTH; i++)
          tab[u][i] <= SAFE;
    end else if (wr_ok) begin
      tab[wr_unit][lin(wr_cls, int'(wr_proc), int'(wr_age), int'(wr_temp), int'(wr_volt))] <= wr_val;
    end
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic [1:0] p_s;
    logic [2:0] a_s, t_s, v_s;
    assign p_s = coarse_mode ? rep_proc : sens_proc[u*2 +: 2];
    assign a_s = coarse_mode ? rep_age  : sens_age[u*3 +: 3];
    assign t_s = coarse_mode ? rep_temp : sens_temp[u*3 +: 3];
    assign v_s = coarse_mode ? rep_volt : sens_volt[u*3 +: 3];
    assign need[u] = (coarse_mode || unit_use[u]) ?
                     tab[u][rd_idx(target_cls, p_s, a_s, t_s, v_s)] : 5'd0;
  end

  always_comb begin
    mx = 5'd0;
    for (int u = 0; u < NUM_UNITS; u++)
      if (need[u] > mx) mx = need[u];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   period_code <= SAFE;
    else if (upd) period_code <= mx;
  end

endmodule

// File: rtl/adaptive_period_sel_chk.sv
module adaptive_period_sel_chk #(
  parameter int NUM_UNITS = 3,
  parameter int CODE_MAX  = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 coarse_mode,
  input logic                 instr_valid,
  input logic [NUM_UNITS-1:0] unit_use,
  input logic [4:0]           period_code
);

  AST_RESET_SAFE: assert property (@(posedge clk) !rst_n |=> period_code == 5'(CODE_MAX)); // R1

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    period_code != 5'd0 && period_code <= 5'(CODE_MAX)); // R12

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!coarse_mode && !instr_valid) |=> $stable(period_code)); // R6

  AST_HOLD_NO_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!coarse_mode && instr_valid && unit_use == '0) |=> $stable(period_code)); // R7

endmodule

bind adaptive_period_sel adaptive_period_sel_chk #(.NUM_UNITS(NUM_UNITS), .CODE_MAX(CODE_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .coarse_mode(coarse_mode), .instr_valid(instr_valid),
  .unit_use(unit_use), .period_code(period_code)
);

// File: tb/adaptive_period_sel_bench.sv
`timescale 1ns/1ps
module adaptive_period_sel_bench;
  localparam int NU = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_unit = '0, wr_cls = '0, wr_proc = '0, target_cls = '0, rep_proc = '0;
  logic [2:0] wr_age = '0, wr_temp = '0, wr_volt = '0, rep_age = '0, rep_temp = '0, rep_volt = '0;
  logic [4:0] wr_code = '0;
  logic coarse_mode = 1'b0, instr_valid = 1'b0;
  logic [NU-1:0] unit_use = '0;
  logic [2*NU-1:0] sens_proc = '0;
  logic [3*NU-1:0] sens_age = '0, sens_temp = '0, sens_volt = '0;
  logic [4:0] period_code;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [4:0] m [NU][4][4][5][4][4];
  logic [4:0] prev_exp;

  always #2 clk = ~clk;

  adaptive_period_sel u_adaptive_period_sel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_unit(wr_unit), .wr_cls(wr_cls),
    .wr_proc(wr_proc), .wr_age(wr_age), .wr_temp(wr_temp), .wr_volt(wr_volt),
    .wr_code(wr_code), .target_cls(target_cls), .coarse_mode(coarse_mode),
    .instr_valid(instr_valid), .unit_use(unit_use), .sens_proc(sens_proc),
    .sens_age(sens_age), .sens_temp(sens_temp), .sens_volt(sens_volt),
    .rep_proc(rep_proc), .rep_age(rep_age), .rep_temp(rep_temp), .rep_volt(rep_volt),
    .period_code(period_code));

  function automatic int cla(input logic [2:0] a); return (a > 3'd4) ? 4 : int'(a); endfunction
  function automatic int clt(input logic [2:0] t); return (t > 3'd3) ? 3 : int'(t); endfunction
  function automatic int clv(input logic [2:0] v); return (v > 3'd3) ? 0 : int'(v); endfunction

  function automatic logic [4:0] look(input int u, input logic [1:0] c, input logic [1:0] p,
                                      input logic [2:0] a, input logic [2:0] t, input logic [2:0] v);
    return m[u][c][p][cla(a)][clt(t)][clv(v)];
  endfunction

  function automatic logic [4:0] expect_code(input logic [4:0] prev);
    logic [4:0] r, x;
    if (!coarse_mode && !(instr_valid && |unit_use)) return prev;
    r = 5'd0;
    for (int u = 0; u < NU; u++) begin
      if (coarse_mode) x = look(u, target_cls, rep_proc, rep_age, rep_temp, rep_volt);
      else if (unit_use[u]) x = look(u, target_cls, sens_proc[u*2 +: 2], sens_age[u*3 +: 3],
                                      sens_temp[u*3 +: 3], sens_volt[u*3 +: 3]);
      else x = 5'd0;
      if (x > r) r = x;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [4:0] exp);
    n_cmp++;
    if (period_code !== exp) begin
      n_bad++;
      $display("FAIL %s: period_code=%0d expected=%0d", req, period_code, exp);
    end
  endtask

  task automatic twrite(input int u, input logic [1:0] c, input logic [1:0] p, input logic [2:0] a,
                        input logic [2:0] t, input logic [2:0] v, input logic [4:0] code);
    wr_en = 1'b1; wr_unit = 2'(u); wr_cls = c; wr_proc = p;
    wr_age = a; wr_temp = t; wr_volt = v; wr_code = code;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    if (u < NU && a <= 3'd4 && t <= 3'd3 && v <= 3'd3)
      m[u][c][p][a][t][v] = (code == 5'd0 || code > 5'd24) ? 5'd24 : code;
  endtask

  task automatic step_check(input string req);
    logic [4:0] e;
    e = expect_code(prev_exp);
    @(posedge clk); @(negedge clk);
    check(req, e);
    prev_exp = e;
  endtask

  task automatic set_unit(input int u, input logic [1:0] p, input logic [2:0] a,
                          input logic [2:0] t, input logic [2:0] v);
    sens_proc[u*2 +: 2] = p; sens_age[u*3 +: 3] = a;
    sens_temp[u*3 +: 3] = t; sens_volt[u*3 +: 3] = v;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    for (int u = 0; u < NU; u++)
      for (int c = 0; c < 4; c++)
        for (int p = 0; p < 4; p++)
          for (int a = 0; a < 5; a++)
            for (int t = 0; t < 4; t++)
              for (int v = 0; v < 4; v++)
                m[u][c][p][a][t][v] = 5'd24;
    repeat (3) @(negedge clk);
    check("R1 reset", 5'd24);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 5'd24);
    prev_exp = 5'd24;

    // R1: untouched entries read back as 24
    instr_valid = 1'b1; unit_use = 3'b111; target_cls = 2'd3;
    set_unit(0, 2'd2, 3'd1, 3'd2, 3'd3); set_unit(1, 2'd0, 3'd0, 3'd0, 3'd0); set_unit(2, 2'd3, 3'd4, 3'd1, 3'd2);
    step_check("R1 reset table");

    // fill tables, a few codes out of range (R10)
    instr_valid = 1'b0;
    for (int u = 0; u < NU; u++)
      for (int c = 0; c < 4; c++)
        for (int p = 0; p < 4; p++)
          for (int a = 0; a < 5; a++)
            for (int t = 0; t < 4; t++)
              for (int v = 0; v < 4; v++) begin
                int r;
                r = $urandom_range(0, 31);
                twrite(u, 2'(c), 2'(p), 3'(a), 3'(t), 3'(v),
                       (r < 2) ? 5'(r * 27) : 5'($urandom_range(1, 24)));
              end

    // constrained random lookups
    for (int i = 0; i < 500; i++) begin
      string tag;
      coarse_mode = ($urandom_range(0, 3) == 0);
      instr_valid = ($urandom_range(0, 3) != 0);
      unit_use = NU'($urandom);
      target_cls = 2'($urandom);
      sens_proc = (2*NU)'($urandom); sens_age = (3*NU)'($urandom);
      sens_temp = (3*NU)'($urandom); sens_volt = (3*NU)'($urandom);
      rep_proc = 2'($urandom); rep_age = 3'($urandom); rep_temp = 3'($urandom); rep_volt = 3'($urandom);
      if (coarse_mode) tag = "R5 kernel max";
      else if (!instr_valid) tag = "R6 hold invalid";
      else if (unit_use == '0) tag = "R7 hold no unit";
      else tag = "R3 per-instr max (R9 clamp, R12)";
      step_check(tag);
    end

    // directed: R2 single unit lookup
    coarse_mode = 1'b0; instr_valid = 1'b0;
    twrite(1, 2'd2, 2'd1, 3'd2, 3'd3, 3'd1, 5'd7);
    twrite(0, 2'd2, 2'd0, 3'd0, 3'd0, 3'd0, 5'd20);
    twrite(2, 2'd2, 2'd0, 3'd0, 3'd0, 3'd0, 5'd22);
    instr_valid = 1'b1; unit_use = 3'b010; target_cls = 2'd2;
    set_unit(1, 2'd1, 3'd2, 3'd3, 3'd1);
    set_unit(0, 2'd0, 3'd0, 3'd0, 3'd0); set_unit(2, 2'd0, 3'd0, 3'd0, 3'd0);
    step_check("R2 written code");
    check("R4 unused units ignored", 5'd7);
    unit_use = 3'b111;
    step_check("R3 max of three");
    check("R3 max value", 5'd22);

    // R8 class sections
    twrite(1, 2'd0, 2'd1, 3'd2, 3'd3, 3'd1, 5'd13);
    unit_use = 3'b010; target_cls = 2'd0;
    step_check("R8 class 0");
    check("R8 class 0 value", 5'd13);
    target_cls = 2'd2;
    step_check("R8 class 2");
    check("R8 class 2 value", 5'd7);

    // R9 clamp
    twrite(0, 2'd1, 2'd3, 3'd4, 3'd3, 3'd0, 5'd19);
    unit_use = 3'b001; target_cls = 2'd1;
    set_unit(0, 2'd3, 3'd7, 3'd6, 3'd5);
    step_check("R9 clamp");
    check("R9 clamp value", 5'd19);

    // R11 illegal write addresses
    twrite(0, 2'd1, 2'd3, 3'd6, 3'd3, 3'd0, 5'd3);
    twrite(3, 2'd1, 2'd3, 3'd4, 3'd3, 3'd0, 5'd4);
    twrite(0, 2'd1, 2'd3, 3'd4, 3'd5, 3'd0, 5'd5);
    set_unit(0, 2'd3, 3'd4, 3'd3, 3'd0);
    step_check("R11 ignored write");
    check("R11 ignored write value", 5'd19);

    // R10 code 0 and code above 24
    twrite(0, 2'd1, 2'd3, 3'd4, 3'd3, 3'd0, 5'd0);
    step_check("R10 code 0");
    check("R10 code 0 value", 5'd24);
    twrite(0, 2'd1, 2'd3, 3'd4, 3'd3, 3'd0, 5'd9);
    step_check("R10 legal rewrite");
    twrite(0, 2'd1, 2'd3, 3'd4, 3'd3, 3'd0, 5'd30);
    step_check("R10 code 30");
    check("R10 code 30 value", 5'd24);

    // R5 kernel mode ignores valid and unit_use
    twrite(2, 2'd1, 2'd3, 3'd4, 3'd3, 3'd0, 5'd2);
    twrite(1, 2'd1, 2'd3, 3'd4, 3'd3, 3'd0, 5'd11);
    twrite(0, 2'd1, 2'd3, 3'd4, 3'd3, 3'd0, 5'd6);
    coarse_mode = 1'b1; instr_valid = 1'b0; unit_use = 3'b000; target_cls = 2'd1;
    rep_proc = 2'd3; rep_age = 3'd5; rep_temp = 3'd7; rep_volt = 3'd6;
    step_check("R5 kernel mode");
    check("R5 kernel value", 5'd11);

    // R6/R7 hold after kernel value
    coarse_mode = 1'b0; instr_valid = 1'b0; unit_use = 3'b111;
    step_check("R6 hold");
    check("R6 hold value", 5'd11);
    instr_valid = 1'b1; unit_use = 3'b000;
    step_check("R7 hold");
    check("R7 hold value", 5'd11);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule